// File: doc/BRIEF.md
# Accumulator Channel to Core Event Mapper

This block sits between the accumulation engine of a queue manager and the interrupt inputs of a four-core cluster. Each of 32 accumulator channels emits a one-cycle completion pulse when it has finished a batch. The block turns that pulse into a one-cycle event on exactly one core. The owning core is the channel number modulo 4. The event slot on that core is the channel number divided by 4, which selects one of the high-priority event numbers 48 to 55. This channel-to-core-and-event steering is fixed wiring and cannot be changed.

Each channel watches a queue, and software may point it at any queue number. A channel-to-queue table holds a 16-bit queue number per channel. A separate per-queue configuration store records whether each queue is armed. A queue is armed only when its configuration register was last written with the code 0x81. A pulse from a channel whose queue is not armed is swallowed, and it sets a sticky drop flag that only reset clears.

Both tables are loaded through one plain write strobe. The pulses carry no payload and cannot be stalled, so the block has no valid/ready handshake and exerts no back-pressure. Every pulse is judged in the cycle it arrives.

Top module: `accevt_mapper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of `core_evt` is 0 and `drop_sticky` is 0. Reset sets the table so that channel c watches queue 704+c, and it disarms every queue.
- R2: A pulse on `chan_done[c]` whose queue is armed raises `core_evt[k*8+n]` in the next cycle, where k = c mod 4 and n = c / 4. This bit stands for event 48+n on core k. The bit is high for one cycle per input pulse, so back-to-back pulses give back-to-back events.
- R3: A pulse raises no `core_evt` bit other than the one named in R2. No `core_evt` bit is high in a cycle that follows a cycle with no pulse.
- R4: A pulse whose queue is not armed raises no event. It sets `drop_sticky` one cycle later, and `drop_sticky` then stays 1 until reset.
- R5: A write with `cfg_target`=1 arms queue `cfg_addr` when `cfg_wdata[7:0]` equals 0x81. Any other low byte disarms that queue. `cfg_wdata[15:8]` is ignored.
- R6: A write with `cfg_target`=0 sets the queue watched by channel `cfg_addr` to `cfg_wdata`. Pulses from that channel are then judged against the new queue.
- R7: A queue number of 1024 or above (the QUEUE_COUNT parameter) is never armed. A queue write to such a number is ignored. A table write to a channel number of 32 or above is ignored and leaves every channel's mapping unchanged.
- R8: A pulse that arrives in the same cycle as a configuration write is judged against the configuration as it stood before that write.
- R9: Pulses on several channels in the same cycle are each forwarded or dropped independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_done | input | 32 | One-cycle completion pulse per accumulator channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 1 | Selects the store to write: 0 = channel-to-queue table, 1 = queue configuration |
| cfg_addr | input | 16 | Channel number (table write) or queue number (queue write) |
| cfg_wdata | input | 16 | Queue number (table write), or configuration code in bits 7:0 (queue write) |
| core_evt | output | 32 | Registered events; bit k*8+n is event 48+n on core k |
| drop_sticky | output | 1 | Set when a pulse is dropped; cleared only by reset |

## Verification
The bench pulses every channel on its own, so a design that swapped the modulo and the quotient would light the wrong core's bit for all but the diagonal channels. It arms one queue with 0x0181 and writes 0x0080 to another, which catches a decoder that compares all 16 bits or only the top bit. It writes an out-of-range queue number and an out-of-range channel number; a design that drops the high address bits would alias these writes onto real entries and wrongly arm or remap them. It also changes a queue's state in the same cycle as a pulse, which exposes a design that bypasses the new value into the lookup, and it fires all channels at once to catch cross-talk between the lookups.

// File: rtl/accevt_pkg.sv
package accevt_pkg;

  typedef enum logic {
    CFG_CHAN_MAP = 1'b0,
    CFG_QUEUE    = 1'b1
  } cfg_target_e;

  localparam logic [7:0] QUEUE_ARM_CODE = 8'h81;

  function automatic int owner_core(input int ch, input int ncores);
    return ch % ncores;
  endfunction

  function automatic int event_slot(input int ch, input int ncores);
    return ch / ncores;
  endfunction

endpackage

// File: rtl/chan_qmap.sv
module chan_qmap #(
  parameter int NUM_CHAN    = 32,
  parameter int QW          = 16,
  parameter int RESET_QBASE = 704
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [QW-1:0]          wr_addr,
  input  logic [QW-1:0]          wr_data,
  output logic [NUM_CHAN*QW-1:0] qmap_flat
);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [QW-1:0] watched_q;
    logic          hit;

    // full-width compare, so channel numbers beyond the table never alias
    assign hit = wr_en && (wr_addr == QW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   watched_q <= QW'(RESET_QBASE + c);
      else if (hit) watched_q <= wr_data;
    end

    assign qmap_flat[c*QW +: QW] = watched_q;
  end

endmodule

// File: rtl/qcfg_store.sv
module qcfg_store
  import accevt_pkg::*;
#(
  parameter int QUEUE_COUNT = 1024,
  parameter int QW          = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [QW-1:0]          wr_addr,
  input  logic [7:0]             wr_code,
  output logic [QUEUE_COUNT-1:0] q_armed
);

  localparam int QIW = $clog2(QUEUE_COUNT);

  logic in_range;
  logic arm_val;

  assign in_range = ({1'b0, wr_addr} < (QW+1)'(QUEUE_COUNT));
  assign arm_val  = (wr_code == QUEUE_ARM_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_armed <= '0;
    end else if (wr_en && in_range) begin
      q_armed[wr_addr[QIW-1:0]] <= arm_val;
    end
  end

endmodule

// File: rtl/evt_router.sv
module evt_router
  import accevt_pkg::*;
#(
  parameter int NUM_CHAN    = 32,
  parameter int NUM_CORES   = 4,
  parameter int QW          = 16,
  parameter int QUEUE_COUNT = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CHAN-1:0]    pulse,
  input  logic [NUM_CHAN*QW-1:0] qmap_flat,
  input  logic [QUEUE_COUNT-1:0] q_armed,
  output logic [NUM_CHAN-1:0]    evt,
  output logic                   drop_sticky
);

  localparam int SLOTS = NUM_CHAN / NUM_CORES;
  localparam int QIW   = $clog2(QUEUE_COUNT);

  logic [NUM_CHAN-1:0] pass;
  logic [NUM_CHAN-1:0] drop;
  logic [NUM_CHAN-1:0] steered;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_path
    localparam int K = owner_core(c, NUM_CORES);
    localparam int N = event_slot(c, NUM_CORES);

    logic [QW-1:0] qn;
    logic          q_ok;
    logic          armed;

    assign qn    = qmap_flat[c*QW +: QW];
    assign q_ok  = ({1'b0, qn} < (QW+1)'(QUEUE_COUNT));
    assign armed = q_ok && q_armed[qn[QIW-1:0]];

    assign pass[c]            = pulse[c] & armed;
    assign drop[c]            = pulse[c] & ~armed;
    assign steered[K*SLOTS+N] = pass[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt         <= '0;
      drop_sticky <= 1'b0;
    end else begin
      evt         <= steered;
      drop_sticky <= drop_sticky | (|drop);
    end
  end

endmodule

// File: rtl/accevt_mapper.sv
module accevt_mapper
  import accevt_pkg::*;
#(
  parameter int NUM_CHAN    = 32,
  parameter int NUM_CORES   = 4,
  parameter int QW          = 16,
  parameter int QUEUE_COUNT = 1024,
  parameter int RESET_QBASE = 704
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CHAN-1:0] chan_done,
  input  logic                cfg_we,
  input  logic                cfg_target,
  input  logic [QW-1:0]       cfg_addr,
  input  logic [QW-1:0]       cfg_wdata,
  output logic [NUM_CHAN-1:0] core_evt,
  output logic                drop_sticky
);

  logic [NUM_CHAN*QW-1:0] qmap_flat;
  logic [QUEUE_COUNT-1:0] q_armed;
  logic                   map_we;
  logic                   queue_we;

  assign map_we   = cfg_we && (cfg_target_e'(cfg_target) == CFG_CHAN_MAP);
  assign queue_we = cfg_we && (cfg_target_e'(cfg_target) == CFG_QUEUE);

  chan_qmap #(
    .NUM_CHAN   (NUM_CHAN),
    .QW         (QW),
    .RESET_QBASE(RESET_QBASE)
  ) u_qmap (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (map_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .qmap_flat(qmap_flat)
  );

  qcfg_store #(
    .QUEUE_COUNT(QUEUE_COUNT),
    .QW         (QW)
  ) u_qcfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (queue_we),
    .wr_addr(cfg_addr),
    .wr_code(cfg_wdata[7:0]),
    .q_armed(q_armed)
  );

  evt_router #(
    .NUM_CHAN   (NUM_CHAN),
    .NUM_CORES  (NUM_CORES),
    .QW         (QW),
    .QUEUE_COUNT(QUEUE_COUNT)
  ) u_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse      (chan_done),
    .qmap_flat  (qmap_flat),
    .q_armed    (q_armed),
    .evt        (core_evt),
    .drop_sticky(drop_sticky)
  );

endmodule

// File: rtl/accevt_mapper_chk.sv
module accevt_mapper_chk #(
  parameter int NUM_CHAN  = 32,
  parameter int NUM_CORES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CHAN-1:0] chan_done,
  input logic [NUM_CHAN-1:0] core_evt,
  input logic                drop_sticky
);

  localparam int SLOTS = NUM_CHAN / NUM_CORES;

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_bit
    localparam int CH = (i % SLOTS) * NUM_CORES + (i / SLOTS);

    AST_EVT_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      core_evt[i] |-> $past(chan_done[CH])); // R2
  end

  AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done == '0) |=> (core_evt == '0)); // R3

  AST_EVT_NOT_MORE_THAN_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(core_evt) <= $countones($past(chan_done))); // R9

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_sticky |=> drop_sticky); // R4

  AST_STICKY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drop_sticky) |-> $past(|chan_done)); // R4

endmodule

bind accevt_mapper accevt_mapper_chk #(
  .NUM_CHAN (NUM_CHAN),
  .NUM_CORES(NUM_CORES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_done  (chan_done),
  .core_evt   (core_evt),
  .drop_sticky(drop_sticky)
);

// File: tb/test_accevt_mapper.sv
module test_accevt_mapper;

  localparam int NCH = 32;
  localparam int NQ  = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] chan_done = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_target = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] core_evt;
  logic        drop_sticky;

  always #10 clk = ~clk;

  accevt_mapper i_accevt_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_done  (chan_done),
    .cfg_we     (cfg_we),
    .cfg_target (cfg_target),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .core_evt   (core_evt),
    .drop_sticky(drop_sticky)
  );

  // behavioural reference
  int          m_map [NCH];
  bit          m_arm [NQ];
  logic [31:0] m_evt = '0;
  bit          m_sticky = 0;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) m_map[c] = 704 + c;
    for (int q = 0; q < NQ; q++) m_arm[q] = 0;
    m_evt    = '0;
    m_sticky = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin : model
    logic [31:0] nxt;
    bit          dropped;
    if (!rst_n) begin
      model_reset();
    end else begin
      nxt     = '0;
      dropped = 0;
      for (int c = 0; c < NCH; c++) begin
        if (chan_done[c]) begin
          if (m_map[c] < NQ && m_arm[m_map[c]]) nxt[(c % 4) * 8 + c / 4] = 1'b1;
          else dropped = 1;
        end
      end
      m_evt = nxt;
      if (dropped) m_sticky = 1;
      if (cfg_we) begin
        if (cfg_target) begin
          if (int'(cfg_addr) < NQ) m_arm[int'(cfg_addr)] = (cfg_wdata[7:0] == 8'h81);
        end else if (int'(cfg_addr) < NCH) begin
          m_map[int'(cfg_addr)] = int'(cfg_wdata);
        end
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (!done) begin
      n_cmp++;
      if (core_evt !== m_evt || drop_sticky !== m_sticky) begin
        n_bad++;
        $display("FAIL %s at %0t: evt=%h sticky=%b expected evt=%h sticky=%b",
                 cur_req, $time, core_evt, drop_sticky, m_evt, m_sticky);
      end
    end
  end

  task automatic drive(input logic [31:0] p, input logic we, input logic tgt,
                       input int addr, input int data);
    @(negedge clk);
    chan_done  = p;
    cfg_we     = we;
    cfg_target = tgt;
    cfg_addr   = 16'(addr);
    cfg_wdata  = 16'(data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R5: arm recommended range; 0x0080 disarms, 0x0181 arms
    cur_req = "R5";
    for (int q = 704; q < 736; q++)
      drive('0, 1'b1, 1'b1, q, (q == 710) ? 'h0080 : (q == 711) ? 'h0181 : 'h0081);
    idle(2);

    // R2: each channel alone (channel 6 stays disarmed)
    cur_req = "R2";
    for (int c = 0; c < NCH; c++) begin
      if (c != 6) begin
        drive(32'h1 << c, 1'b0, 1'b0, 0, 0);
        idle(1);
      end
    end
    drive(32'h0000_0002, 1'b0, 1'b0, 0, 0);
    drive(32'h0000_0002, 1'b0, 1'b0, 0, 0);
    idle(2);

    // R3: two channels together, no other bit
    cur_req = "R3";
    drive(32'h8000_0001, 1'b0, 1'b0, 0, 0);
    idle(2);

    // R9: every armed channel at once
    cur_req = "R9";
    drive(32'hFFFF_FFBF, 1'b0, 1'b0, 0, 0);
    idle(2);

    // R5: disarmed queue 710 drops channel 6, 0x0181 arms queue 711 for channel 7
    cur_req = "R5";
    drive(32'h0000_00C0, 1'b0, 1'b0, 0, 0);
    idle(2);

    // R4: drop flag stays set
    cur_req = "R4";
    idle(4);
    drive(32'h0000_0010, 1'b0, 1'b0, 0, 0);
    idle(2);

    cur_req = "R1";
    do_reset();
    idle(2);

    // R7: out-of-range queue and channel writes
    cur_req = "R7";
    drive('0, 1'b1, 1'b1, 712, 'h81);
    drive('0, 1'b1, 1'b1, 2000, 'h81);
    drive('0, 1'b1, 1'b0, 40, 5);
    drive('0, 1'b1, 1'b0, 3, 2000);
    idle(1);
    drive(32'h0000_0100, 1'b0, 1'b0, 0, 0);
    idle(2);
    drive(32'h0000_0008, 1'b0, 1'b0, 0, 0);
    idle(2);

    cur_req = "R1";
    do_reset();
    idle(2);

    // R6: remap channel 5 to queue 100
    cur_req = "R6";
    drive(32'h0000_0020, 1'b0, 1'b0, 0, 0);
    idle(1);
    drive('0, 1'b1, 1'b0, 5, 100);
    drive('0, 1'b1, 1'b1, 100, 'h81);
    drive(32'h0000_0020, 1'b0, 1'b0, 0, 0);
    idle(2);

    // R8: write in the same cycle as a pulse uses the old state
    cur_req = "R8";
    drive('0, 1'b1, 1'b1, 713, 'h81);
    drive(32'h0000_0200, 1'b1, 1'b1, 713, 'h00);
    drive(32'h0000_0200, 1'b0, 1'b0, 0, 0);
    drive(32'h0000_0200, 1'b1, 1'b1, 713, 'h81);
    drive(32'h0000_0200, 1'b0, 1'b0, 0, 0);
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule